// File: doc/BRIEF.md
# Flash Protected-Range Access Guard

This block decides whether a flash cycle may proceed. Before the cycle engine starts a transfer it presents the start address, the byte count (as count minus one) and the access kind. The guard compares the whole byte span against a bank of protected ranges and answers with a single permit/deny pulse. The engine turns a deny into its access-error flag. A bank of flash-region descriptors is also held. The guard decodes it only to report which regions are enabled.

Both register banks are written over a 32-bit register port and read back through a combinational read path. Once the lockdown input has been seen high, every later write is ignored until reset. The check runs as a small state machine. In `ST_IDLE` it waits for a request and captures it (transition *accept*). In `ST_SCAN` it visits one range per cycle. It leaves early on a hit (transition *hit*) or after the last range (transition *exhausted*). `ST_REPORT` emits the one-cycle response and then returns to `ST_IDLE` (transition *release*).

Top module: `fpc_access_guard`

## Requirements
- R1: Range register n sits at byte offset 0x80+4n and region register n at 0x54+4n. A range word holds base in bits 13:0, read-protect enable in bit 15, limit in bits 29:16 and write-protect enable in bit 31. A region word holds base in bits 13:0 and limit in bits 29:16. Every other bit reads back as 0.
- R2: A range covers byte addresses base*4096 through limit*4096+4095, both ends inclusive. A range whose limit is below its base covers nothing.
- R3: req_kind encodes 0 as read, 1 as write, 2 as erase and 3 as reserved, and the reserved code is treated like a write. A write or erase is denied when its span overlaps a range with write protection enabled. Write protection alone never denies a read.
- R4: A read is denied when its span overlaps a range with read protection enabled. Read protection alone never denies a write or erase.
- R5: A range with both enables clear never causes a denial, whatever its base and limit.
- R6: Overlap is judged over the whole span from req_addr to req_addr+req_len_m1. A span whose last byte is the first protected byte is denied. A span ending one byte below the range is permitted.
- R7: region_enabled[n] is 1 exactly when region n's base is below its limit and its limit is nonzero.
- R8: A register write in a cycle where lockdown is high is ignored. So is every write after any cycle with lockdown high, until reset, even once lockdown has returned low.
- R9: A request is accepted when req_valid is high and busy is low. Each accepted request produces exactly one single-cycle resp_valid pulse, no more than NUM_RANGES+1 cycles after acceptance. req_valid while busy is ignored.
- R10: After reset all registers read 0, busy, resp_valid and resp_permit are low, and region_enabled is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| lockdown | input | 1 | Freezes the register banks from its first high cycle |
| req_valid | input | 1 | Check request |
| req_addr | input | 26 | First byte of the span |
| req_len_m1 | input | LEN_W | Span length minus one |
| req_kind | input | 2 | Access kind (0 read, 1 write, 2 erase, 3 reserved) |
| busy | output | 1 | A check is in progress |
| resp_valid | output | 1 | Decision pulse |
| resp_permit | output | 1 | Access allowed (valid with resp_valid) |
| region_enabled | output | NUM_REGIONS | Enabled mask of the flash regions |

## Verification
The properties assume that the range bank does not change while a check is in flight. A denial is checked only against the enables present when the response leaves. The stimulus therefore programs and locks the registers only while busy is low, and starts a new request only after the previous one has finished. The one exception is a deliberate second req_valid held into the busy window, which must be ignored. Spans are chosen to land exactly on inclusive range edges, one byte either side, on an inverted range and on a range with no enable.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    // Flash address granularity: a unit index plus a byte offset inside the unit
    localparam int UNIT_W   = 14;
    localparam int PAGE_W   = 12;
    localparam int FLASH_AW = UNIT_W + PAGE_W;
    // One extra bit so that start + length never wraps
    localparam int SPAN_W   = FLASH_AW + 1;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_ERASE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_REPORT = 2'd2
    } scan_state_t;

    typedef struct packed {
        logic              wp;
        logic              rp;
        logic [UNIT_W-1:0] lim;
        logic [UNIT_W-1:0] base;
    } prange_t;

    typedef struct packed {
        logic [UNIT_W-1:0] lim;
        logic [UNIT_W-1:0] base;
    } fregion_t;

endpackage

// File: rtl/fpc_cfg_regs.sv
module fpc_cfg_regs
    import fpc_pkg::*;
#(
    parameter int                NUM_RANGES  = 5,
    parameter int                NUM_REGIONS = 6,
    parameter int                CFG_AW      = 8,
    parameter logic [CFG_AW-1:0] RNG_OFF     = 8'h80,
    parameter logic [CFG_AW-1:0] REG_OFF     = 8'h54
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              lockdown,
    output logic              lock_q,
    output prange_t           rng_q [NUM_RANGES],
    output fregion_t          reg_q [NUM_REGIONS]
);

    localparam int LIM_LSB = 16;

    logic wr_ok;
    logic unused_wbits;

    assign wr_ok        = cfg_we && !lock_q && !lockdown;
    assign unused_wbits = ^{cfg_wdata[30], cfg_wdata[14]};

    // Sticky freeze: any high cycle on lockdown holds until reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= 1'b0;
        else if (lockdown) lock_q <= 1'b1;
    end

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_rng
        localparam logic [CFG_AW-1:0] OFF = RNG_OFF + CFG_AW'(4 * i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rng_q[i] <= '0;
            end else if (wr_ok && cfg_addr == OFF) begin
                rng_q[i].wp   <= cfg_wdata[31];
                rng_q[i].rp   <= cfg_wdata[15];
                rng_q[i].lim  <= cfg_wdata[LIM_LSB +: UNIT_W];
                rng_q[i].base <= cfg_wdata[UNIT_W-1:0];
            end
        end
    end

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
        localparam logic [CFG_AW-1:0] OFF = REG_OFF + CFG_AW'(4 * r);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_q[r] <= '0;
            end else if (wr_ok && cfg_addr == OFF) begin
                reg_q[r].lim  <= cfg_wdata[LIM_LSB +: UNIT_W];
                reg_q[r].base <= cfg_wdata[UNIT_W-1:0];
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (cfg_addr == RNG_OFF + CFG_AW'(4 * i)) begin
                cfg_rdata = {rng_q[i].wp, 1'b0, rng_q[i].lim,
                             rng_q[i].rp, 1'b0, rng_q[i].base};
            end
        end
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (cfg_addr == REG_OFF + CFG_AW'(4 * r)) begin
                cfg_rdata = {2'b00, reg_q[r].lim, 2'b00, reg_q[r].base};
            end
        end
    end

endmodule

// File: rtl/fpc_region_decode.sv
module fpc_region_decode
    import fpc_pkg::*;
#(
    parameter int NUM_REGIONS = 6
) (
    input  fregion_t               regn [NUM_REGIONS],
    output logic [NUM_REGIONS-1:0] enabled
);

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_dec
        // Empty or inverted descriptors, and any with a zero limit, are off
        assign enabled[r] = (regn[r].base < regn[r].lim) && (regn[r].lim != '0);
    end

endmodule

// File: rtl/fpc_range_match.sv
module fpc_range_match
    import fpc_pkg::*;
(
    input  prange_t           rng,
    input  logic [SPAN_W-1:0] first,
    input  logic [SPAN_W-1:0] last,
    input  logic              want_write,
    output logic              hit
);

    logic [SPAN_W-1:0] lo;
    logic [SPAN_W-1:0] hi;
    logic              armed;
    logic              sane;

    assign lo    = {1'b0, rng.base, {PAGE_W{1'b0}}};
    assign hi    = {1'b0, rng.lim,  {PAGE_W{1'b1}}};
    assign armed = want_write ? rng.wp : rng.rp;
    assign sane  = rng.base <= rng.lim;
    assign hit   = armed && sane && (first <= hi) && (last >= lo);

endmodule

// File: rtl/fpc_scan_fsm.sv
module fpc_scan_fsm
    import fpc_pkg::*;
#(
    parameter int NUM_RANGES = 5,
    parameter int LEN_W      = 6,
    parameter int IDX_W      = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [FLASH_AW-1:0] req_addr,
    input  logic [LEN_W-1:0]    req_len_m1,
    input  logic [1:0]          req_kind,
    input  logic                hit,
    output logic [IDX_W-1:0]    idx,
    output logic [SPAN_W-1:0]   span_first,
    output logic [SPAN_W-1:0]   span_last,
    output logic                want_write,
    output logic                busy,
    output logic                resp_valid,
    output logic                resp_permit
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_RANGES - 1);

    scan_state_t state_q, state_d;
    logic        deny_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_SCAN;
            ST_SCAN:   if (hit || idx == LAST_IDX) state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture and scan bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx        <= '0;
            deny_q     <= 1'b0;
            span_first <= '0;
            span_last  <= '0;
            want_write <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        idx        <= '0;
                        deny_q     <= 1'b0;
                        span_first <= {1'b0, req_addr};
                        span_last  <= {1'b0, req_addr} + SPAN_W'(req_len_m1);
                        want_write <= (req_kind != ACC_READ);
                    end
                end
                ST_SCAN: begin
                    if (hit) deny_q <= 1'b1;
                    else if (idx != LAST_IDX) idx <= idx + 1'b1;
                end
                ST_REPORT: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy        = (state_q != ST_IDLE);
        resp_valid  = (state_q == ST_REPORT);
        resp_permit = (state_q == ST_REPORT) && !deny_q;
    end

endmodule

// File: rtl/fpc_access_guard.sv
module fpc_access_guard
    import fpc_pkg::*;
#(
    parameter int                NUM_RANGES  = 5,
    parameter int                NUM_REGIONS = 6,
    parameter int                LEN_W       = 6,
    parameter int                CFG_AW      = 8,
    parameter logic [CFG_AW-1:0] RNG_OFF     = 8'h80,
    parameter logic [CFG_AW-1:0] REG_OFF     = 8'h54
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [31:0]            cfg_wdata,
    output logic [31:0]            cfg_rdata,
    input  logic                   lockdown,
    input  logic                   req_valid,
    input  logic [FLASH_AW-1:0]    req_addr,
    input  logic [LEN_W-1:0]       req_len_m1,
    input  logic [1:0]             req_kind,
    output logic                   busy,
    output logic                   resp_valid,
    output logic                   resp_permit,
    output logic [NUM_REGIONS-1:0] region_enabled
);

    localparam int IDX_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1;

    logic              lock_q;
    prange_t           rng_q [NUM_RANGES];
    fregion_t          reg_q [NUM_REGIONS];
    logic [IDX_W-1:0]  scan_idx;
    logic [SPAN_W-1:0] span_first;
    logic [SPAN_W-1:0] span_last;
    logic              want_write;
    logic              range_hit;
    prange_t           cur_rng;

    fpc_cfg_regs #(
        .NUM_RANGES (NUM_RANGES),
        .NUM_REGIONS(NUM_REGIONS),
        .CFG_AW     (CFG_AW),
        .RNG_OFF    (RNG_OFF),
        .REG_OFF    (REG_OFF)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .lockdown (lockdown),
        .lock_q   (lock_q),
        .rng_q    (rng_q),
        .reg_q    (reg_q)
    );

    fpc_region_decode #(
        .NUM_REGIONS(NUM_REGIONS)
    ) u_regdec (
        .regn   (reg_q),
        .enabled(region_enabled)
    );

    assign cur_rng = rng_q[scan_idx];

    fpc_range_match u_match (
        .rng       (cur_rng),
        .first     (span_first),
        .last      (span_last),
        .want_write(want_write),
        .hit       (range_hit)
    );

    fpc_scan_fsm #(
        .NUM_RANGES(NUM_RANGES),
        .LEN_W     (LEN_W),
        .IDX_W     (IDX_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_len_m1 (req_len_m1),
        .req_kind   (req_kind),
        .hit        (range_hit),
        .idx        (scan_idx),
        .span_first (span_first),
        .span_last  (span_last),
        .want_write (want_write),
        .busy       (busy),
        .resp_valid (resp_valid),
        .resp_permit(resp_permit)
    );

endmodule

// File: rtl/fpc_access_guard_chk.sv
module fpc_access_guard_chk
    import fpc_pkg::*;
#(
    parameter int NUM_RANGES  = 5,
    parameter int NUM_REGIONS = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_we,
    input logic                   locked,
    input logic                   req_valid,
    input logic                   busy,
    input logic                   resp_valid,
    input logic                   resp_permit,
    input logic [NUM_REGIONS-1:0] region_enabled,
    input prange_t                rng [NUM_RANGES],
    input fregion_t               regn [NUM_REGIONS]
);

    logic any_armed;

    always_comb begin
        any_armed = 1'b0;
        for (int i = 0; i < NUM_RANGES; i++) any_armed = any_armed | rng[i].wp | rng[i].rp;
    end

    p_resp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    p_resp_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> busy);

    p_permit_qual_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_permit |-> resp_valid);

    // R5: a denial needs at least one armed range
    p_deny_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_permit) |-> any_armed);

    for (genvar i = 0; i < NUM_RANGES; i++) begin : g_rng_freeze
        p_lock_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (locked && cfg_we) |=> $stable(rng[i]));
    end

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg_chk
        p_region_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (locked && cfg_we) |=> $stable(regn[r]));
        p_region_lim_r7: assert property (@(posedge clk) disable iff (!rst_n)
            region_enabled[r] |-> (regn[r].lim != '0));
    end

endmodule

bind fpc_access_guard fpc_access_guard_chk #(
    .NUM_RANGES (NUM_RANGES),
    .NUM_REGIONS(NUM_REGIONS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .locked        (lock_q),
    .req_valid     (req_valid),
    .busy          (busy),
    .resp_valid    (resp_valid),
    .resp_permit   (resp_permit),
    .region_enabled(region_enabled),
    .rng           (rng_q),
    .regn          (reg_q)
);

// File: tb/test_fpc_access_guard.sv
module test_fpc_access_guard;

    localparam int NR = 5;
    localparam int NG = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lockdown = 1'b0;
    logic        req_valid = 1'b0;
    logic [25:0] req_addr = '0;
    logic [5:0]  req_len_m1 = '0;
    logic [1:0]  req_kind = '0;
    logic        busy, resp_valid, resp_permit;
    logic [NG-1:0] region_enabled;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    fpc_access_guard i_fpc_access_guard (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lockdown(lockdown),
        .req_valid(req_valid), .req_addr(req_addr), .req_len_m1(req_len_m1),
        .req_kind(req_kind), .busy(busy), .resp_valid(resp_valid),
        .resp_permit(resp_permit), .region_enabled(region_enabled)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected decision per response pulse
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 response without request", 1, 0);
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(resp_permit == e, t, resp_permit, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    // Driver: queues the expected decision, issues the request, waits for completion
    task automatic send(input logic [25:0] a, input logic [5:0] l, input logic [1:0] k,
                        input bit exp_permit, input string tag, input bit hold = 1'b0);
        int cyc = 0;
        @(negedge clk);
        exp_q.push_back(exp_permit);
        tag_q.push_back(tag);
        req_addr = a; req_len_m1 = l; req_kind = k; req_valid = 1'b1;
        @(negedge clk);
        if (hold) begin
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        while (busy) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc <= NR + 1, "R9 latency", cyc, NR + 1);
    endtask

    function automatic logic [31:0] rword(bit wp, bit rp, logic [13:0] lim, logic [13:0] base);
        return {wp, 1'b0, lim, rp, 1'b0, base};
    endfunction

    initial begin
        #(20ns * 200000);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        #1;
        check(busy == 1'b0 && resp_valid == 1'b0 && resp_permit == 1'b0, "R10 outputs idle",
              {busy, resp_valid, resp_permit}, 0);
        check(region_enabled == '0, "R10 regions off", region_enabled, 0);
        rd_check(8'h80, 32'h0, "R10 range0 cleared");
        rd_check(8'h54, 32'h0, "R10 region0 cleared");

        // R1: field layout, junk bits 30 and 14 dropped
        wr(8'h80, 32'hFFFF_FFFF);
        rd_check(8'h80, 32'hBFFF_BFFF, "R1 range readback");
        wr(8'h58, 32'hFFFF_FFFF);
        rd_check(8'h58, 32'h3FFF_3FFF, "R1 region readback");
        wr(8'h58, 32'h0);

        // Range setup
        wr(8'h80, rword(1, 0, 14'h00F, 14'h008)); // 0x8000..0xFFFF write-protected
        wr(8'h84, rword(0, 1, 14'h020, 14'h020)); // 0x20000..0x20FFF read-protected
        wr(8'h88, rword(0, 0, 14'h031, 14'h030)); // no enables
        wr(8'h8C, rword(1, 1, 14'h040, 14'h050)); // inverted
        wr(8'h90, 32'h0);
        rd_check(8'h84, 32'h0020_8020, "R1 range1 readback");

        send(26'h0007FC0, 6'd63, 2'd1, 1'b1, "R6 span ends below range");
        send(26'h0007FC1, 6'd63, 2'd1, 1'b0, "R6 span last byte on range base");
        send(26'h0008000, 6'd0,  2'd0, 1'b1, "R3 read ignores write protect");
        send(26'h000FFFF, 6'd0,  2'd2, 1'b0, "R2 erase on inclusive top byte");
        send(26'h0010000, 6'd0,  2'd1, 1'b1, "R2 write just past limit");
        send(26'h0009000, 6'd3,  2'd3, 1'b0, "R3 reserved kind acts as write");
        send(26'h0020FFF, 6'd0,  2'd0, 1'b0, "R4 read top byte of read range");
        send(26'h0021000, 6'd0,  2'd0, 1'b1, "R4 read past read range");
        send(26'h0020000, 6'd15, 2'd1, 1'b1, "R4 write ignores read protect");
        send(26'h001FFF0, 6'd63, 2'd0, 1'b0, "R6 read span crossing into range");
        send(26'h0030800, 6'd7,  2'd0, 1'b1, "R5 disarmed range read");
        send(26'h0031000, 6'd7,  2'd2, 1'b1, "R5 disarmed range erase");
        send(26'h0045000, 6'd63, 2'd1, 1'b1, "R2 inverted range covers nothing");
        send(26'h0100000, 6'd0,  2'd0, 1'b1, "R9 held req_valid", 1'b1);
        check(exp_q.size() == 0, "R9 held request gave one response", exp_q.size(), 0);

        // R7: region decode
        wr(8'h54, 32'h01FF_0000);  // base 0 lim 0x1FF  -> on
        wr(8'h58, 32'h0005_0005);  // equal              -> off
        wr(8'h5C, 32'h0002_0006);  // inverted           -> off
        wr(8'h60, 32'h0000_0000);  // zero               -> off
        wr(8'h64, 32'h3FFF_0100);  // on
        wr(8'h68, 32'h0001_0000);  // base 0 lim 1       -> on
        #1;
        check(region_enabled == 6'b110001, "R7 region mask", region_enabled, 6'b110001);

        // R8: write in the lockdown cycle is ignored, and the freeze persists
        @(negedge clk);
        lockdown = 1'b1; cfg_we = 1'b1; cfg_addr = 8'h80; cfg_wdata = 32'h0;
        @(negedge clk);
        lockdown = 1'b0; cfg_we = 1'b0;
        wr(8'h80, 32'h0);
        wr(8'h68, 32'h0);
        rd_check(8'h80, rword(1, 0, 14'h00F, 14'h008), "R8 range frozen");
        rd_check(8'h68, 32'h0001_0000, "R8 region frozen");
        send(26'h0008000, 6'd0, 2'd1, 1'b0, "R8 protection kept after lock");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 all responses seen", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule